// File: doc/BRIEF.md
# Serial Flash Bus Front End

This block sits between the four-wire serial bus of a flash memory device and its command decoder. It turns serial bit streams into whole bytes and whole bytes back into serial bit streams. A local system clock oversamples SCK and chip select. Bits come in most significant first on every rising SCK edge. Outgoing bits change on every falling SCK edge. The block works whether SCK rests low or high between transactions, so no setting is needed to choose between the two clock polarities.

Each received byte reaches the decoder as a one-cycle strobe. The decoder offers the next outgoing byte on `tx_byte`, and the block takes it at the moment a byte completes. A pause pin freezes a transfer partway through without losing its position. A quad-enable input turns the write-protect and pause pins into data lanes two and three. The decoder can then ask for four bits per SCK cycle. The block also reports whether the hardware write-protect pin is currently holding the status register locked. Raising chip select partway through a byte is reported to the decoder as an abort.

Top module: `spi_flash_front`

## Requirements
- R1: The block receives correctly whether SCK is low or high when `cs_n` falls. If the first SCK edge of a transaction is a falling edge, it is not counted as a data edge.
- R2: While `cs_n` is 1, the outputs behave as follows:
  - `io_oe` is 0000.
  - `rx_valid` stays 0.
  - The bit position, receive shifter and transmit shifter return to their start state, so every `cs_n` fall begins a transaction at bit 0.
- R3: In single mode, `io_in[0]` is sampled on each rising SCK edge, most significant bit first. After every 8th rising edge, `rx_valid` is 1 for exactly one clock, one clock after the edge is seen, with the assembled byte on `rx_byte`.
- R4: When a byte completes, `tx_byte` is captured. On each following falling SCK edge, the next bit is driven, most significant first. In single mode the bit appears on `io_out[1]` and `io_oe` is 0010.
- R5: With `qe`=0 and `cs_n`=0, `io_in[3]`=0 pauses the bus. While paused, SCK edges are ignored and `io_oe` is 0000, but the bit position and both shifters are kept. The transfer continues from the same bit once `io_in[3]` returns to 1.
- R6: With `qe`=1, `io_in[3]` no longer pauses the bus and `io_in[2]` no longer write-protects.
- R7: Quad mode applies when `qe`=1 and `quad_sel`=1:
  - Each rising edge takes a nibble from `io_in[3:0]`, with `io_in[3]` as its most significant bit, and a byte completes every 2 rising edges.
  - Each falling edge drives a nibble on `io_out[3:0]`, with `io_out[3]` as its most significant bit, and `io_oe` is 1111.
  - `quad_sel` has no effect while `qe`=0.
- R8: If `cs_n` rises while the bit position is not on a byte boundary, `abort` is 1 for exactly one clock. A rise on a byte boundary gives no abort.
- R9: `hw_protect` is 1 exactly when `qe`=0 and `io_in[2]`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock, already synchronised to `clk` |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 4 | Pin levels: data in, data out, write-protect or lane 2, pause or lane 3 |
| io_out | output | 4 | Values to drive on the four data pins |
| io_oe | output | 4 | Per-pin output enable; 0 means high impedance |
| qe | input | 1 | Quad-enable bit from the status register |
| quad_sel | input | 1 | Decoder request for four-lane transfer |
| tx_byte | input | 8 | Next byte to send, captured at byte completion |
| rx_byte | output | 8 | Last byte received |
| rx_valid | output | 1 | One-clock strobe marking a new `rx_byte` |
| abort | output | 1 | One-clock strobe: transaction ended mid-byte |
| hw_protect | output | 1 | Write-protect pin is active and is locking the status register |

## Verification
Two of the block's functions can act in the same clock. One pair is a pause that starts in the very cycle an SCK rising edge arrives. The other pair is chip select rising in the very cycle an SCK edge arrives. The bench drives `io_in[3]` low together with `sck` high, and later `cs_n` high together with `sck` high, both in a single input update. A behavioural bit-queue model checks every clock that the edge is dropped, that the dropped bit is accepted when it is sent again after the pause, and that the partial byte produces an abort rather than a byte.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    localparam int LANES = 4;

    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_QUAD   = 1'b1
    } xfer_mode_e;
endpackage

// File: rtl/spi_fe_edges.sv
// Oversamples SCK and chip select, and qualifies SCK edges with select and pause.
module spi_fe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic hold_n,
    input  logic qe,
    output logic sck_rise,
    output logic sck_fall,
    output logic active,
    output logic cs_rise
);
    typedef struct packed {
        logic sck;
        logic cs_n;
    } edge_st_t;

    edge_st_t d, q;
    logic     held;

    always_comb begin
        d.sck    = sck;
        d.cs_n   = cs_n;
        held     = ~qe & ~hold_n & ~cs_n;
        active   = ~cs_n & ~held;
        sck_rise = active & sck & ~q.sck;
        sck_fall = active & ~sck & q.sck;
        cs_rise  = cs_n & ~q.cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sck: 1'b0, cs_n: 1'b1};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/spi_fe_shift.sv
// Bit counter and receive/transmit shifters, in single-lane or four-lane steps.
module spi_fe_shift
    import spi_fe_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          cs_n,
    input  logic          cs_rise,
    input  xfer_mode_e    mode,
    input  logic [3:0]    io_in,
    input  logic [DW-1:0] tx_word,
    output logic [DW-1:0] rx_word,
    output logic          rx_strobe,
    output logic          abort,
    output logic [3:0]    lanes
);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] rx_sh;
        logic [DW-1:0] tx_sh;
        logic [3:0]    lanes;
        logic [DW-1:0] rx_word;
        logic          rx_strobe;
        logic          abort;
    } shift_st_t;

    shift_st_t d, q;
    logic [CW:0] step;
    logic [CW:0] sum;

    always_comb begin
        d           = q;
        d.rx_strobe = 1'b0;
        d.abort     = 1'b0;
        step        = (mode == XFER_QUAD) ? (CW+1)'(LANES) : (CW+1)'(1);
        sum         = {1'b0, q.cnt} + step;
        if (cs_n) begin
            d.abort = cs_rise & (q.cnt != '0);
            d.cnt   = '0;
            d.rx_sh = '0;
            d.tx_sh = '0;
            d.lanes = '0;
        end else begin
            if (sck_rise) begin
                if (mode == XFER_QUAD) begin
                    d.rx_sh = {q.rx_sh[DW-LANES-1:0], io_in};
                end else begin
                    d.rx_sh = {q.rx_sh[DW-2:0], io_in[0]};
                end
                d.cnt = sum[CW-1:0];
                if (sum[CW]) begin
                    d.rx_strobe = 1'b1;
                    d.rx_word   = d.rx_sh;
                    d.tx_sh     = tx_word;
                end
            end
            if (sck_fall) begin
                if (mode == XFER_QUAD) begin
                    d.lanes = q.tx_sh[DW-1 -: LANES];
                    d.tx_sh = q.tx_sh << LANES;
                end else begin
                    d.lanes = {2'b00, q.tx_sh[DW-1], 1'b0};
                    d.tx_sh = q.tx_sh << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_word   = q.rx_word;
    assign rx_strobe = q.rx_strobe;
    assign abort     = q.abort;
    assign lanes     = q.lanes;

    // R3: a byte strobe never lasts two clocks
    p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.rx_strobe |=> !q.rx_strobe);

    // R2: no byte can appear after a clock with chip select high
    p_quiet_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !q.rx_strobe);

    // R5: with no qualified edge, position and transmit data are kept
    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sck_rise && !sck_fall) |=>
            ($stable(q.cnt) && $stable(q.tx_sh) && $stable(q.lanes)));

    // R8: an abort only follows a partial byte
    p_abort_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.abort |-> ($past(q.cnt) != '0));
endmodule

// File: rtl/spi_flash_front.sv
// Serial flash bus front end: top level.
module spi_flash_front
    import spi_fe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic              qe,
    input  logic              quad_sel,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              abort,
    output logic              hw_protect
);
    logic       sck_rise, sck_fall, active, cs_rise;
    xfer_mode_e mode;
    logic [3:0] lanes;

    spi_fe_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .hold_n   (io_in[3]),
        .qe       (qe),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .active   (active),
        .cs_rise  (cs_rise)
    );

    spi_fe_shift #(.DW(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_n      (cs_n),
        .cs_rise   (cs_rise),
        .mode      (mode),
        .io_in     (io_in),
        .tx_word   (tx_byte),
        .rx_word   (rx_byte),
        .rx_strobe (rx_valid),
        .abort     (abort),
        .lanes     (lanes)
    );

    always_comb begin
        mode       = (qe & quad_sel) ? XFER_QUAD : XFER_SINGLE;
        io_out     = lanes;
        hw_protect = ~qe & ~io_in[2];
        if (!active) begin
            io_oe = 4'b0000;
        end else if (mode == XFER_QUAD) begin
            io_oe = 4'b1111;
        end else begin
            io_oe = 4'b0010;
        end
    end

    // R2: deselected pins float
    p_deselect_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (io_oe == 4'b0000));

    // R5: a pause floats every pin
    p_hold_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!qe && !io_in[3] && !cs_n) |-> (io_oe == 4'b0000));

    // R6: lanes 2 and 3 are never driven without quad enable
    p_quad_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !qe |-> (io_oe[3:2] == 2'b00));

    // R4: outside quad mode at most one pin drives
    p_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(qe && quad_sel) |-> $onehot0(io_oe));
endmodule

// File: tb/spi_flash_front_test.sv
module spi_flash_front_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] io_in = 4'b1100;
    logic       qe = 1'b0;
    logic       quad_sel = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [3:0] io_out, io_oe;
    logic [7:0] rx_byte;
    logic       rx_valid, abort, hw_protect;

    spi_flash_front uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .qe(qe), .quad_sel(quad_sel),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .abort(abort), .hw_protect(hw_protect)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R2 reset";

    // behavioural reference model
    bit       m_sck, m_csp, m_valid, m_abort;
    int       m_bits, m_rx, m_byte;
    bit       q_tx[$];
    int       m_out;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sck = 0; m_csp = 1; m_valid = 0; m_abort = 0;
            m_bits = 0; m_rx = 0; m_byte = 0; m_out = 0;
            q_tx.delete();
        end else begin
            bit held, act, quad;
            held = !qe && !io_in[3] && !cs_n;
            act  = !cs_n && !held;
            quad = qe && quad_sel;
            m_valid = 0;
            m_abort = 0;
            if (cs_n) begin
                m_abort = !m_csp && (m_bits % 8 != 0);
                m_bits = 0; m_rx = 0; m_out = 0;
                q_tx.delete();
            end else if (act) begin
                if (sck && !m_sck) begin
                    if (quad) begin
                        m_rx = ((m_rx << 4) | int'(io_in)) & 255;
                        m_bits += 4;
                    end else begin
                        m_rx = ((m_rx << 1) | int'(io_in[0])) & 255;
                        m_bits += 1;
                    end
                    if (m_bits % 8 == 0) begin
                        m_valid = 1;
                        m_byte  = m_rx;
                        q_tx.delete();
                        for (int i = 7; i >= 0; i--) q_tx.push_back(tx_byte[i]);
                    end
                end else if (!sck && m_sck) begin
                    int nib;
                    nib = 0;
                    for (int k = 0; k < (quad ? 4 : 1); k++) begin
                        bit b;
                        b = (q_tx.size() > 0) ? q_tx.pop_front() : 1'b0;
                        nib = (nib << 1) | int'(b);
                    end
                    m_out = quad ? nib : (nib << 1);
                end
            end
            m_sck = sck;
            m_csp = cs_n;
        end
    end

    task automatic chk(string what, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act_v, exp_v);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int exp_oe;
            bit held, act;
            held = !qe && !io_in[3] && !cs_n;
            act  = !cs_n && !held;
            exp_oe = !act ? 0 : ((qe && quad_sel) ? 15 : 2);
            chk("rx_valid R3/R7", int'(rx_valid), int'(m_valid));
            if (m_valid) chk("rx_byte R3/R7", int'(rx_byte), m_byte);
            chk("io_oe R2/R5/R7", int'(io_oe), exp_oe);
            chk("io_out R4/R7", int'(io_out & io_oe), m_out & exp_oe);
            chk("abort R8", int'(abort), int'(m_abort));
            chk("hw_protect R9/R6", int'(hw_protect), int'(!qe && !io_in[2]));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog all act=%0d exp=done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic tbit(bit b);
        sck = 1'b0; io_in[0] = b; step(2);
        sck = 1'b1; step(2);
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) tbit(b[i]);
    endtask

    task automatic send_nib(logic [3:0] n);
        sck = 1'b0; io_in = n; step(2);
        sck = 1'b1; step(2);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        cur_req = "R2 idle"; step(4);

        // mode 0 framing, receive and transmit
        cur_req = "R3 R4 mode0";
        cs_n = 1'b0; step(2);
        tx_byte = 8'hA5; send_byte(8'h3B);
        tx_byte = 8'h5C; send_byte(8'h81);
        send_byte(8'hFF);
        sck = 1'b0; step(2);
        cs_n = 1'b1; step(3);

        // mode 3: clock rests high
        cur_req = "R1 mode3";
        sck = 1'b1; step(2);
        cs_n = 1'b0; step(2);
        tx_byte = 8'hC3; send_byte(8'h6E);
        send_byte(8'h12);
        cs_n = 1'b1; step(3);

        // pause, including a pause landing on a rising edge
        cur_req = "R5 hold";
        sck = 1'b0; step(1);
        cs_n = 1'b0; step(2);
        tx_byte = 8'h96; send_byte(8'h47);
        tbit(1'b1); tbit(1'b1); tbit(1'b0);
        sck = 1'b0; io_in[0] = 1'b0; step(2);
        sck = 1'b1; io_in[3] = 1'b0; step(2);
        sck = 1'b0; io_in[0] = 1'b1; step(2);
        sck = 1'b1; step(2);
        sck = 1'b0; step(2);
        io_in[3] = 1'b1; step(2);
        tbit(1'b0); tbit(1'b1); tbit(1'b1); tbit(1'b0); tbit(1'b1);
        sck = 1'b0; step(2);
        cs_n = 1'b1; step(3);

        // write-protect pin qualifier
        cur_req = "R9 wp";
        io_in[2] = 1'b0; step(3);
        io_in[2] = 1'b1; step(2);

        // quad enable: pause pin becomes a lane
        cur_req = "R6 qe";
        qe = 1'b1; io_in = 4'b0000; step(2);
        cs_n = 1'b0; step(2);
        tx_byte = 8'h3C; send_byte(8'hD2);
        send_byte(8'h0F);
        sck = 1'b0; step(2);
        cs_n = 1'b1; step(3);

        // four-lane transfer after a single-lane command byte
        cur_req = "R7 quad";
        cs_n = 1'b0; step(2);
        tx_byte = 8'h9E; send_byte(8'hEB);
        quad_sel = 1'b1;
        tx_byte = 8'h71;
        send_nib(4'h3); send_nib(4'hC);
        send_nib(4'hA); send_nib(4'h5);
        send_nib(4'h0); send_nib(4'hF);
        sck = 1'b0; step(2);
        cs_n = 1'b1; step(3);

        // quad request without quad enable stays single
        cur_req = "R7 gated";
        qe = 1'b0; io_in = 4'b1100; step(2);
        cs_n = 1'b0; step(2);
        tx_byte = 8'hB4; send_byte(8'h5A);
        send_byte(8'hC9);
        sck = 1'b0; step(2);
        cs_n = 1'b1; step(3);
        quad_sel = 1'b0;

        // partial byte ends the transaction
        cur_req = "R8 abort";
        cs_n = 1'b0; step(2);
        tbit(1'b1); tbit(1'b0); tbit(1'b1);
        sck = 1'b0; step(2);
        cs_n = 1'b1; step(3);
        cs_n = 1'b0; step(2);
        tbit(1'b0); tbit(1'b1); tbit(1'b1); tbit(1'b0);
        sck = 1'b0; io_in[0] = 1'b1; step(2);
        sck = 1'b1; cs_n = 1'b1; step(3);
        sck = 1'b0; step(3);

        step(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule